// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Acknowledge Sequencer

This block sits beside an instruction fetch and execute pipeline. It decides at which instruction boundary a pending interrupt is taken. Once it has decided, it runs a fixed entry sequence that stalls fetch, strobes the status-word save, strobes the program-counter save and finally strobes a jump carrying the vector index of the chosen source.

Each source has a latched request flag, a mask bit and a fixed priority. The fetch side marks the first clock of every instruction with a strobe and the instruction's length in clocks. The block tracks the clocks of that instruction and makes its choice in the final one. Because it looks only at flags already latched, a request that arrives in the final clock waits for one more complete instruction. While software touches the flag or mask registers, no request is taken.

Nesting follows a current in-service level. A source can interrupt only if its priority exceeds that level. Each acknowledge pushes the old level onto a 4-entry stack, and a return strobe pops it back.

The controller has five states:
- `ST_RUN`: normal execution.
- `ST_SAVE_PSW`: entry clock 1.
- `ST_SAVE_PC`: entry clock 2.
- `ST_HOLD`: entry clocks 3 to 7.
- `ST_JUMP`: entry clock 8.

Its transitions are:
- RUN→SAVE_PSW when an acknowledge is decided.
- SAVE_PSW→SAVE_PC, always.
- SAVE_PC→HOLD, always.
- HOLD→HOLD while the hold counter is non-zero.
- HOLD→JUMP when the hold counter reaches zero.
- JUMP→RUN, always.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset, stall, save_psw, save_pc and jump are 0, isr_level is 0 and no request is pending.
- R2: A request raised in clock k of an n-clock instruction, with k ≤ n−1, makes stall rise in the clock right after that instruction's last clock.
- R3: A request first raised in the final clock of an instruction is not taken after it. The following instruction runs all its clocks, and stall rises in the clock after that instruction ends.
- R4: The entry sequence lasts exactly 8 clocks with stall high in all of them. save_psw is high only in entry clock 1, save_pc only in entry clock 2 and jump only in entry clock 8. At most one of the three strobes is high in any clock, and stall is low in the clock after jump.
- R5: vec_idx equals the index of the acknowledged source and is stable from entry clock 1 to entry clock 8.
- R6: If regs_busy is high in the final clock of an instruction, no acknowledge starts at that boundary. The request stays pending and is taken at the next boundary where regs_busy is low.
- R7: Priority values are larger for more urgent sources. By default source 0 has priority 3, sources 1 and 2 have priority 2, and source 3 has priority 1. Among pending unmasked sources the highest priority wins, and on a tie the lower index wins.
- R8: A pending source is acknowledged only if its priority is strictly greater than isr_level. Level 0 means no routine is in service.
- R9: A source whose mask_in bit is 1 is never acknowledged, but its flag stays latched. Once the mask bit clears, the source is taken at the next boundary with no new request.
- R10: Acknowledge clears the chosen source's flag, so it is not taken again without a new request. isr_level equals that source's priority from entry clock 1 on and does not change during the entry.
- R11: A reti pulse outside the entry sequence restores the level that was in service before the latest acknowledge. Up to 4 nested levels are held.
- R12: A clr_in bit of 1 drops that source's pending flag, so the source is not acknowledged later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | N_SRC | Request pulses; a 1 sets the source's flag |
| mask_in | input | N_SRC | 1 blocks the source from acknowledge |
| clr_in | input | N_SRC | 1 clears the source's pending flag |
| regs_busy | input | 1 | Flag or mask registers are being accessed |
| instr_start | input | 1 | First clock of an instruction |
| instr_len | input | LEN_W | Clock count of the starting instruction |
| reti | input | 1 | Return from interrupt; pops the level stack |
| stall | output | 1 | Hold fetch during the entry sequence |
| save_psw | output | 1 | Save status word (entry clock 1) |
| save_pc | output | 1 | Save program counter (entry clock 2) |
| jump | output | 1 | Jump to handler (entry clock 8) |
| vec_idx | output | IDX_W | Index of acknowledged source |
| isr_level | output | PRIO_W | Current in-service priority level |

## Verification
Every output comes from a register, so each is due one clock after the edge that ends the stimulus clock. For stall and save_psw, the due clock is the one after the final clock of the deciding instruction: n cycles after instr_start for R2, and n1+n2 cycles after it for R3 and R6. The other strobes follow at fixed entry offsets 2 and 8, and a reti or clr_in shows one clock later. The bench drives and samples only on falling edges and advances one whole clock between samples, so each check lands in exactly the cycle computed for it.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_SAVE_PSW,
        ST_SAVE_PC,
        ST_HOLD,
        ST_JUMP
    } seq_state_t;

endpackage

// File: rtl/irq_req_flags.sv
module irq_req_flags #(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] req_in,
    input  logic [N_SRC-1:0] clr_in,
    input  logic [N_SRC-1:0] ack_clr,
    output logic [N_SRC-1:0] flags
);

    // a fresh request in the same clock outranks any clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_in & ~ack_clr) | req_in;
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int                     N_SRC    = 4,
    parameter int                     PRIO_W   = 2,
    parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO = 8'h6B,
    localparam int                    IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]  cand,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx,
    output logic [PRIO_W-1:0] win_prio
);

    logic [PRIO_W-1:0] prio_of [N_SRC];

    for (genvar g = 0; g < N_SRC; g++) begin : g_prio
        assign prio_of[g] = SRC_PRIO[g*PRIO_W +: PRIO_W];
    end

    // scan from the top index down; ">=" lets lower indices win ties
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!win_valid || prio_of[i] >= win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = prio_of[i];
            end
        end
    end

endmodule

// File: rtl/irq_boundary_track.sv
module irq_boundary_track #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_start,
    input  logic [LEN_W-1:0] instr_len,
    output logic             last_clk
);

    logic [LEN_W-1:0] rem_q;

    assign last_clk = instr_start ? (instr_len == LEN_W'(1)) : (rem_q == LEN_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (instr_start) begin
            rem_q <= (instr_len == '0) ? '0 : instr_len - 1'b1;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack #(
    parameter int PRIO_W = 2,
    parameter int DEPTH  = 4,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SP_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_level,
    input  logic              pop,
    output logic [PRIO_W-1:0] level
);

    localparam logic [SP_W-1:0] SP_FULL = SP_W'(DEPTH);

    logic [PRIO_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]   sp_q;
    logic [SP_W-1:0]   sp_dec;

    assign sp_dec = sp_q - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q  <= '0;
            level <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (push) begin
            if (sp_q < SP_FULL) begin
                mem[sp_q[AW-1:0]] <= level;
                sp_q              <= sp_q + 1'b1;
            end
            level <= push_level;
        end else if (pop) begin
            if (sp_q != '0) begin
                level <= mem[sp_dec[AW-1:0]];
                sp_q  <= sp_dec;
            end else begin
                level <= '0;
            end
        end
    end

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_seq_pkg::*;
#(
    parameter int                      N_SRC     = 4,
    parameter int                      PRIO_W    = 2,
    parameter logic [N_SRC*PRIO_W-1:0] SRC_PRIO  = 8'h6B,
    parameter int                      LEN_W     = 4,
    parameter int                      ENTRY_CYC = 8,
    parameter int                      STK_DEPTH = 4,
    localparam int                     IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  req_in,
    input  logic [N_SRC-1:0]  mask_in,
    input  logic [N_SRC-1:0]  clr_in,
    input  logic              regs_busy,
    input  logic              instr_start,
    input  logic [LEN_W-1:0]  instr_len,
    input  logic              reti,
    output logic              stall,
    output logic              save_psw,
    output logic              save_pc,
    output logic              jump,
    output logic [IDX_W-1:0]  vec_idx,
    output logic [PRIO_W-1:0] isr_level
);

    localparam int HOLD_CYC = ENTRY_CYC - 3;
    localparam int HC_W     = $clog2(ENTRY_CYC);

    seq_state_t        state_q, state_d;
    logic [HC_W-1:0]   hold_q;
    logic [N_SRC-1:0]  flags;
    logic [N_SRC-1:0]  ack_clr;
    logic              win_valid;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic              last_clk;
    logic              take;
    logic              pop;

    irq_req_flags #(.N_SRC(N_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .clr_in  (clr_in),
        .ack_clr (ack_clr),
        .flags   (flags)
    );

    irq_prio_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .SRC_PRIO(SRC_PRIO)) u_pick (
        .cand      (flags & ~mask_in),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    irq_boundary_track #(.LEN_W(LEN_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .instr_start (instr_start && (state_q == ST_RUN)),
        .instr_len   (instr_len),
        .last_clk    (last_clk)
    );

    irq_level_stack #(.PRIO_W(PRIO_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (take),
        .push_level (win_prio),
        .pop        (pop),
        .level      (isr_level)
    );

    // decision uses flags latched before the final clock, so a final-clock
    // request only becomes visible at the next instruction's final clock
    assign take = (state_q == ST_RUN) && last_clk && !regs_busy
                  && win_valid && (win_prio > isr_level);
    assign pop  = reti && (state_q == ST_RUN) && !take;

    always_comb begin
        ack_clr = '0;
        if (take) begin
            ack_clr[win_idx] = 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (take) state_d = ST_SAVE_PSW;
            ST_SAVE_PSW: state_d = ST_SAVE_PC;
            ST_SAVE_PC:  state_d = ST_HOLD;
            ST_HOLD:     if (hold_q == '0) state_d = ST_JUMP;
            ST_JUMP:     state_d = ST_RUN;
            default:     state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            hold_q  <= '0;
            vec_idx <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                vec_idx <= win_idx;
            end
            if (state_q == ST_SAVE_PC) begin
                hold_q <= HC_W'(HOLD_CYC - 1);
            end else if (state_q == ST_HOLD && hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
        end
    end

    always_comb begin
        stall    = 1'b1;
        save_psw = 1'b0;
        save_pc  = 1'b0;
        jump     = 1'b0;
        unique case (state_q)
            ST_RUN:      stall    = 1'b0;
            ST_SAVE_PSW: save_psw = 1'b1;
            ST_SAVE_PC:  save_pc  = 1'b1;
            ST_HOLD:     stall    = 1'b1;
            ST_JUMP:     jump     = 1'b1;
            default:     stall    = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk #(
    parameter int IDX_W     = 2,
    parameter int PRIO_W    = 2,
    parameter int ENTRY_CYC = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stall,
    input logic              save_psw,
    input logic              save_pc,
    input logic              jump,
    input logic [IDX_W-1:0]  vec_idx,
    input logic [PRIO_W-1:0] isr_level
);

    logic [7:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!stall) begin
            run_cnt <= '0;
        end else if (run_cnt != 8'hFF) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_JUMP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        jump |-> (run_cnt == 8'(ENTRY_CYC - 1))); // R4
    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (run_cnt < 8'(ENTRY_CYC))); // R4
    AST_PSW_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> save_psw); // R4
    AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        save_psw |=> save_pc); // R4
    AST_JUMP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> !stall); // R4
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_psw, save_pc, jump})); // R4
    AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && $past(stall)) |-> $stable(vec_idx)); // R5
    AST_NEST_HIGHER: assert property (@(posedge clk) disable iff (!rst_n)
        save_psw |-> (isr_level > $past(isr_level))); // R8
    AST_LEVEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !save_psw) |-> $stable(isr_level)); // R10

endmodule

bind irq_ack_seq irq_ack_seq_chk #(
    .IDX_W     (IDX_W),
    .PRIO_W    (PRIO_W),
    .ENTRY_CYC (ENTRY_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall     (stall),
    .save_psw  (save_psw),
    .save_pc   (save_pc),
    .jump      (jump),
    .vec_idx   (vec_idx),
    .isr_level (isr_level)
);

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req_in, mask_in, clr_in;
    logic       regs_busy, instr_start, reti;
    logic [3:0] instr_len;
    logic       stall, save_psw, save_pc, jump;
    logic [1:0] vec_idx, isr_level;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irq_ack_seq i_irq_ack_seq (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_in(mask_in),
        .clr_in(clr_in), .regs_busy(regs_busy), .instr_start(instr_start),
        .instr_len(instr_len), .reti(reti), .stall(stall), .save_psw(save_psw),
        .save_pc(save_pc), .jump(jump), .vec_idx(vec_idx), .isr_level(isr_level)
    );

    // fields: src[14:13] k[12:9] n1[8:5] n2[4:1] busy[0]
    localparam logic [14:0] VEC [8] = '{
        {2'd0, 4'd1,  4'd4,  4'd4, 1'b0},
        {2'd1, 4'd3,  4'd4,  4'd4, 1'b0},
        {2'd2, 4'd4,  4'd4,  4'd6, 1'b0},
        {2'd3, 4'd2,  4'd2,  4'd4, 1'b0},
        {2'd0, 4'd1,  4'd10, 4'd2, 1'b0},
        {2'd1, 4'd5,  4'd10, 4'd3, 1'b0},
        {2'd2, 4'd1,  4'd6,  4'd4, 1'b1},
        {2'd3, 4'd10, 4'd10, 4'd3, 1'b0}
    };

    function automatic int prio_of(input int s);
        case (s)
            0:       return 3;
            1:       return 2;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_instr(input int n, input logic [3:0] rv, input int k, input bit bz);
        for (int c = 0; c < n; c++) begin
            instr_start = (c == 0);
            instr_len   = 4'(n);
            req_in      = (c == k - 1) ? rv : 4'h0;
            regs_busy   = bz && (c == n - 1);
            step();
        end
        instr_start = 1'b0;
        req_in      = '0;
        regs_busy   = 1'b0;
    endtask

    // called when the observed cycle is entry clock 1
    task automatic check_entry(input int ev, input int el, input string rq);
        chk({rq, " R4 stall c1"}, int'(stall), 1);
        chk({rq, " R4 save_psw c1"}, int'(save_psw), 1);
        chk({rq, " R5 vec c1"}, int'(vec_idx), ev);
        chk({rq, " R10 level"}, int'(isr_level), el);
        step();
        chk({rq, " R4 save_pc c2"}, int'(save_pc), 1);
        for (int c = 3; c <= 7; c++) begin
            step();
            chk({rq, " R4 hold stall"}, int'(stall && !jump && !save_psw && !save_pc), 1);
        end
        step();
        chk({rq, " R4 jump c8"}, int'(jump), 1);
        chk({rq, " R5 vec c8"}, int'(vec_idx), ev);
        step();
        chk({rq, " R4 released"}, int'(stall), 0);
    endtask

    task automatic do_reti(input int el);
        reti = 1'b1;
        step();
        reti = 1'b0;
        chk("R11 level after reti", int'(isr_level), el);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_in = '0; mask_in = '0; clr_in = '0;
        regs_busy = 1'b0; instr_start = 1'b0; instr_len = '0; reti = 1'b0;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 stall", int'(stall), 0);
        chk("R1 strobes", int'({save_psw, save_pc, jump}), 0);
        chk("R1 level", int'(isr_level), 0);
        run_instr(4, 4'h0, 0, 0);
        chk("R1 nothing pending", int'(stall), 0);

        // vector table: boundary timing (R2 / R3 / R6)
        for (int v = 0; v < 8; v++) begin
            int s, k, n1, n2;
            bit bz, late;
            string tag;
            s  = int'(VEC[v][14:13]);
            k  = int'(VEC[v][12:9]);
            n1 = int'(VEC[v][8:5]);
            n2 = int'(VEC[v][4:1]);
            bz = VEC[v][0];
            late = (k == n1) || bz;
            tag = bz ? "R6" : ((k == n1) ? "R3" : "R2");
            run_instr(n1, 4'(1 << s), k, bz);
            if (late) begin
                chk({tag, " no take at first boundary"}, int'(stall), 0);
                run_instr(n2, 4'h0, 0, 0);
            end
            chk({tag, " stall due"}, int'(stall), 1);
            check_entry(s, prio_of(s), tag);
            do_reti(0);
        end

        // R7 priority and tie-break
        run_instr(4, 4'b1110, 1, 0);
        chk("R7 winner taken", int'(stall), 1);
        check_entry(1, 2, "R7");
        // R8: source 2 at equal level must wait
        run_instr(4, 4'h0, 0, 0);
        chk("R8 equal level blocked", int'(stall), 0);
        do_reti(0);
        run_instr(4, 4'h0, 0, 0);
        chk("R10 tie loser still pending", int'(stall), 1);
        check_entry(2, 2, "R7");
        do_reti(0);
        run_instr(4, 4'h0, 0, 0);
        chk("R7 lowest taken last", int'(stall), 1);
        check_entry(3, 1, "R7");
        do_reti(0);

        // R8 / R11 three-deep nesting
        run_instr(4, 4'b1000, 1, 0);
        check_entry(3, 1, "R8");
        run_instr(4, 4'b0010, 2, 0);
        chk("R8 higher nests", int'(stall), 1);
        check_entry(1, 2, "R8");
        run_instr(3, 4'b0001, 1, 0);
        chk("R8 top nests", int'(stall), 1);
        check_entry(0, 3, "R8");
        do_reti(2);
        do_reti(1);
        do_reti(0);

        // R9 masked stays latched
        mask_in = 4'b0001;
        run_instr(4, 4'b0001, 1, 0);
        chk("R9 masked not taken", int'(stall), 0);
        run_instr(3, 4'h0, 0, 0);
        chk("R9 masked still not taken", int'(stall), 0);
        mask_in = 4'b0000;
        run_instr(4, 4'h0, 0, 0);
        chk("R9 taken after unmask", int'(stall), 1);
        check_entry(0, 3, "R9");
        do_reti(0);
        run_instr(4, 4'h0, 0, 0);
        chk("R10 flag cleared by ack", int'(stall), 0);

        // R12 software clear
        mask_in = 4'b0010;
        run_instr(4, 4'b0010, 1, 0);
        chk("R12 masked pending", int'(stall), 0);
        clr_in = 4'b0010;
        step();
        clr_in = 4'b0000;
        mask_in = 4'b0000;
        run_instr(4, 4'h0, 0, 0);
        chk("R12 cleared flag not taken", int'(stall), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule